// File: doc/BRIEF.md
# One-hot pushbutton selector latch

This block takes a small group of mechanical pushbuttons, from two to four, each pulling its line low while held. It brings every line into the clock domain, removes contact bounce, and keeps a latched one-hot choice that names the button most recently held on its own. The choice drives an active-low output vector in which exactly one line is low at any time. This suits front-panel mode selection, where a user picks one of a few options and the pick stays in place after the finger lifts.

A press counts only when it is the sole button held after filtering. When two or more buttons are held together the pattern is rejected and the latched choice stays as it is. Once the user lets go of buttons until only one is still held, that one becomes the choice at once. This is rollover, and it applies even when the remaining button is not the current choice. Reset loads a fixed default choice, the second output. A one-cycle pulse marks every cycle in which the latched choice takes a new value.

Top module: `pb_select_latch`

## Requirements
- R1: The output `sel_n` always has exactly one bit at 0 (active low). The bit index equals the button index, with `key_n[i]` choosing `sel_n[i]`.
- R2: When exactly one filtered button is held, `sel_n` shows that button on the next clock edge. The choice is kept after the button is released.
- R3: Pressing and releasing the button that is already chosen leaves `sel_n` unchanged and produces no `sel_changed` pulse.
- R4: While two or more filtered buttons are held, `sel_n` does not change.
- R5: When a multi-button hold is released down to a single held button, that button becomes the choice, whether or not it was the previous choice.
- R6: While `rst_n` is low at a clock edge, `sel_n` becomes the default pattern with only bit `DEFAULT_SEL` (default 1) low. In the same condition `sel_changed` becomes 0 and every button filter returns to "released".
- R7: A raw level change on a button reaches the selection logic only if the synchronised level stays constant for `DEBOUNCE_CYCLES` consecutive clock cycles. Shorter glitches are ignored.
- R8: `sel_changed` is high for exactly one cycle, in the same cycle that `sel_n` first shows a new value, and is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| key_n | input | NUM_KEYS | Raw button lines, low while held, asynchronous |
| sel_n | output | NUM_KEYS | Latched one-hot choice, active low |
| sel_changed | output | 1 | One-cycle pulse when the choice takes a new value |

## Verification
Suppose a raw button change is first sampled at rising edge k and then holds steady. The filtered level flips at edge k+DEBOUNCE_CYCLES+1, and `sel_n` and `sel_changed` then update together at edge k+DEBOUNCE_CYCLES+2. The bench drives inputs and compares outputs on falling edges. A behavioural model runs on each rising edge and decides from a queue of raw samples whether the filter would accept a change; the bench compares this model with the design every cycle. Explicit checks wait well beyond DEBOUNCE_CYCLES+3 edges after every stimulus before they sample.

// File: rtl/pb_select_pkg.sv
// Shared helpers for the pushbutton selector.
// Assumes no selector instance has more than MAX_KEYS buttons.
package pb_select_pkg;
    localparam int MAX_KEYS = 8;

    // Number of set bits in a zero-extended button vector.
    function automatic int unsigned count_set(input logic [MAX_KEYS-1:0] v);
        int unsigned n;
        n = 0;
        for (int i = 0; i < MAX_KEYS; i++) begin
            n = n + int'(v[i]);
        end
        return n;
    endfunction
endpackage

// File: rtl/pb_sync2.sv
// Two-flop synchroniser for a vector of asynchronous active-low button lines.
// Assumes each line is sampled independently; reset loads "released" (1).
module pb_sync2 #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_n,
    output logic [WIDTH-1:0] sync_n
);
    logic [WIDTH-1:0] stage1_n;

    // Shift the raw levels through two register stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_n <= '1;
            sync_n   <= '1;
        end else begin
            stage1_n <= raw_n;
            sync_n   <= stage1_n;
        end
    end
endmodule

// File: rtl/pb_debounce.sv
// Per-button bounce filter. A button's filtered level (1 = held) follows its
// synchronised line only after the line has disagreed with it for
// STABLE_CYCLES consecutive cycles. Assumes STABLE_CYCLES >= 2.
module pb_debounce #(
    parameter int WIDTH         = 4,
    parameter int STABLE_CYCLES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] sync_n,
    output logic [WIDTH-1:0] held
);
    localparam int CW = $clog2(STABLE_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(STABLE_CYCLES - 1);

    for (genvar g = 0; g < WIDTH; g++) begin : g_key
        logic [CW-1:0] run_cnt;
        logic          level;
        logic          want;

        assign want = ~sync_n[g];

        // Count cycles of disagreement; adopt the new level after the full run.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                run_cnt <= '0;
                level   <= 1'b0;
            end else if (want != level) begin
                if (run_cnt == LAST) begin
                    level   <= want;
                    run_cnt <= '0;
                end else begin
                    run_cnt <= run_cnt + 1'b1;
                end
            end else begin
                run_cnt <= '0;
            end
        end

        assign held[g] = level;
    end
endmodule

// File: rtl/pb_choice_reg.sv
// Selection register. Loads the one-hot held pattern whenever exactly one
// filtered button is held and it differs from the stored choice; any other
// pattern keeps the choice. Flags each load with a one-cycle pulse.
// Assumes DEFAULT_SEL < WIDTH <= pb_select_pkg::MAX_KEYS.
module pb_choice_reg
    import pb_select_pkg::*;
#(
    parameter int WIDTH       = 4,
    parameter int DEFAULT_SEL = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] held,
    output logic [WIDTH-1:0] choice,
    output logic             loaded
);
    localparam logic [WIDTH-1:0] DEF_CHOICE = {{(WIDTH-1){1'b0}}, 1'b1} << DEFAULT_SEL;

    logic lone_press;
    logic differs;

    // Decide whether the held pattern is a lone, new press.
    always_comb begin
        lone_press = (count_set(MAX_KEYS'(held)) == 1);
        differs    = (held != choice);
    end

    // Store the choice and raise the load pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            choice <= DEF_CHOICE;
            loaded <= 1'b0;
        end else if (lone_press && differs) begin
            choice <= held;
            loaded <= 1'b1;
        end else begin
            loaded <= 1'b0;
        end
    end
endmodule

// File: rtl/pb_select_latch.sv
// Top of the pushbutton selector: synchroniser, bounce filter and selection
// register in series. Buttons and the choice output are active low.
// Assumes 2 <= NUM_KEYS <= 4 and a free-running clk.
module pb_select_latch #(
    parameter int NUM_KEYS        = 4,
    parameter int DEBOUNCE_CYCLES = 16,
    parameter int DEFAULT_SEL     = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_KEYS-1:0] key_n,
    output logic [NUM_KEYS-1:0] sel_n,
    output logic                sel_changed
);
    logic [NUM_KEYS-1:0] key_sync_n;
    logic [NUM_KEYS-1:0] held_db;
    logic [NUM_KEYS-1:0] choice;

    pb_sync2 #(.WIDTH(NUM_KEYS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_n  (key_n),
        .sync_n (key_sync_n)
    );

    pb_debounce #(.WIDTH(NUM_KEYS), .STABLE_CYCLES(DEBOUNCE_CYCLES)) u_filter (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_n (key_sync_n),
        .held   (held_db)
    );

    pb_choice_reg #(.WIDTH(NUM_KEYS), .DEFAULT_SEL(DEFAULT_SEL)) u_choice (
        .clk    (clk),
        .rst_n  (rst_n),
        .held   (held_db),
        .choice (choice),
        .loaded (sel_changed)
    );

    assign sel_n = ~choice;
endmodule

// File: rtl/pb_select_latch_chk.sv
// Property checker for pb_select_latch, attached by bind below. It watches
// the filtered held vector and the outputs of the top module.
module pb_select_latch_chk
    import pb_select_pkg::*;
#(
    parameter int NUM_KEYS    = 4,
    parameter int DEFAULT_SEL = 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_KEYS-1:0] held_db,
    input logic [NUM_KEYS-1:0] sel_n,
    input logic                sel_changed
);
    localparam logic [NUM_KEYS-1:0] DEF_N = ~({{(NUM_KEYS-1){1'b0}}, 1'b1} << DEFAULT_SEL);

    // R1: exactly one active-low output line.
    a_r1_one_low: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(~sel_n));

    // R2: a lone held button is shown on the next edge.
    a_r2_lone_load: assert property (@(posedge clk) disable iff (!rst_n)
        (count_set(MAX_KEYS'(held_db)) == 1) |=> (~sel_n == $past(held_db)));

    // R4: no change while zero or several buttons are held.
    a_r4_multi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (count_set(MAX_KEYS'(held_db)) != 1) |=> $stable(sel_n));

    // R6: reset loads the default choice and clears the pulse.
    a_r6_reset_default: assert property (@(posedge clk)
        !rst_n |=> (sel_n == DEF_N && !sel_changed));

    // R8: the pulse coincides with a new value.
    a_r8_pulse_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        sel_changed |-> (sel_n != $past(sel_n)));

    // R8: every new value carries the pulse.
    a_r8_change_has_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n != $past(sel_n)) |-> sel_changed);
endmodule

bind pb_select_latch pb_select_latch_chk #(
    .NUM_KEYS    (NUM_KEYS),
    .DEFAULT_SEL (DEFAULT_SEL)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .held_db     (held_db),
    .sel_n       (sel_n),
    .sel_changed (sel_changed)
);

// File: tb/pb_select_latch_bench.sv
// Bench for pb_select_latch: behavioural reference model compared on every
// clock, plus scenario checks with fixed expected patterns.
module pb_select_latch_bench;
    localparam int N = 4;
    localparam int D = 16;
    localparam int SETTLE = D + 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] key_n = '1;
    logic [N-1:0] sel_n;
    logic         sel_changed;

    int checks = 0;
    int failures = 0;
    int pulses = 0;
    string phase_req = "R6";

    always #5 clk = ~clk;

    pb_select_latch #(.NUM_KEYS(N), .DEBOUNCE_CYCLES(D), .DEFAULT_SEL(1)) u_pb_select_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .key_n       (key_n),
        .sel_n       (sel_n),
        .sel_changed (sel_changed)
    );

    // Reference model state: queue of raw held samples, newest first.
    logic [N-1:0] hist[$];
    logic [N-1:0] m_held = '0;
    logic [N-1:0] m_sel = 4'b0010;
    logic         m_pulse = 1'b0;
    bit           model_live = 0;

    // Model step on each rising edge.
    always @(posedge clk) begin
        int ones;
        model_live <= 1;
        if (!rst_n) begin
            hist.delete();
            for (int k = 0; k <= D; k++) hist.push_front('0);
            m_held  = '0;
            m_sel   = 4'b0010;
            m_pulse = 1'b0;
        end else begin
            ones = 0;
            for (int i = 0; i < N; i++) ones += int'(m_held[i]);
            m_pulse = 1'b0;
            if (ones == 1 && m_held != m_sel) begin
                m_sel   = m_held;
                m_pulse = 1'b1;
            end
            for (int i = 0; i < N; i++) begin
                bit steady;
                steady = 1;
                for (int k = 1; k <= D; k++) if (hist[k][i] != hist[1][i]) steady = 0;
                if (steady && hist[1][i] != m_held[i]) m_held[i] = hist[1][i];
            end
            hist.push_front(~key_n);
            void'(hist.pop_back());
        end
    end

    // Compare against the model on every falling edge.
    always @(negedge clk) begin
        if (model_live) begin
            checks++;
            if (sel_n !== ~m_sel || sel_changed !== m_pulse) begin
                failures++;
                $display("FAIL %s model: sel_n=%b chg=%b expected sel_n=%b chg=%b",
                         phase_req, sel_n, sel_changed, ~m_sel, m_pulse);
            end
            checks++;
            if ($countones(~sel_n) != 1) begin
                failures++;
                $display("FAIL R1 one-low: sel_n=%b expected exactly one 0", sel_n);
            end
            if (sel_changed === 1'b1) pulses++;
        end
    end

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic drive(input logic [N-1:0] v, input int cyc);
        @(negedge clk);
        key_n = v;
        repeat (cyc) @(negedge clk);
    endtask

    task automatic run_tests();
        int p0;
        repeat (4) @(negedge clk);
        chk("R6 default", sel_n, 4'b1101);
        chk("R6 pulse low", {3'b000, sel_changed}, 4'b0000);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R6 after release", sel_n, 4'b1101);

        phase_req = "R2";
        drive(4'b1110, SETTLE);
        chk("R2 press key0", sel_n, 4'b1110);
        drive(4'b1111, SETTLE);
        chk("R2 latched after release", sel_n, 4'b1110);

        phase_req = "R7";
        drive(4'b0111, 5);
        drive(4'b1111, 3);
        drive(4'b0111, D - 4);
        drive(4'b1111, SETTLE);
        chk("R7 short glitches ignored", sel_n, 4'b1110);
        drive(4'b0111, 4);
        drive(4'b1111, 2);
        drive(4'b0111, SETTLE);
        chk("R7 bouncing press accepted", sel_n, 4'b0111);
        drive(4'b1111, SETTLE);

        phase_req = "R3";
        p0 = pulses;
        drive(4'b0111, SETTLE);
        drive(4'b1111, SETTLE);
        chk("R3 same key again", sel_n, 4'b0111);
        chk("R3 no pulse", 4'(pulses - p0), 4'd0);

        phase_req = "R4";
        drive(4'b0000, 2 * SETTLE);
        chk("R4 all held", sel_n, 4'b0111);
        drive(4'b1111, SETTLE);
        chk("R4 all released together", sel_n, 4'b0111);

        phase_req = "R5";
        drive(4'b1101, SETTLE);
        chk("R2 press key1", sel_n, 4'b1101);
        drive(4'b1001, SETTLE);
        chk("R4 key1+key2 held", sel_n, 4'b1101);
        drive(4'b1011, SETTLE);
        chk("R5 rollover to key2", sel_n, 4'b1011);
        drive(4'b1111, SETTLE);
        chk("R5 key2 kept", sel_n, 4'b1011);

        drive(4'b1110, SETTLE);
        chk("R2 press key0 again", sel_n, 4'b1110);
        drive(4'b1010, SETTLE);
        chk("R4 key0+key2 held", sel_n, 4'b1110);
        drive(4'b1110, SETTLE);
        chk("R5 remaining key0 stays", sel_n, 4'b1110);
        drive(4'b1111, SETTLE);

        phase_req = "R8";
        chk("R8 pulse count", 4'(pulses), 4'd5);

        phase_req = "R6";
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R6 reset restores default", sel_n, 4'b1101);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        fork
            run_tests();
            begin
                repeat (100000) @(posedge clk);
                failures++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule